// File: doc/BRIEF.md
# Saturating Bidirectional Arithmetic Shifter

This block shifts a signed fixed-point operand by a signed count. The sign of the count picks the direction: zero or positive shifts left, negative shifts right by the magnitude of the count. Left shifts never wrap. When the shifted value no longer fits the selected word, the result is clamped to the largest or smallest value of that word, and an overflow flag is raised. Right shifts are arithmetic. An optional rounding mode adds one half of the last discarded weight, which rounds half up.

A mode input selects a 32-bit word or a 16-bit word. In 16-bit mode only the low half of the operand takes part, and the result is returned sign-extended to the full port width. The shift logic is combinational. The result, the overflow flag and a valid strobe are registered one clock after an input-valid pulse, so the block fits into a pipelined datapath.

Top module: `sat_shifter`

## Requirements
- R1: A `shift_cnt` of zero or above shifts left by that amount. A negative `shift_cnt` shifts right by its magnitude, and -128 means a right shift by 128.
- R2: A left shift whose value does not fit the selected word clamps to the word's largest value for a non-negative operand and to its smallest value for a negative operand. In 32-bit mode these are 0x7FFFFFFF and 0x80000000. In 16-bit mode these are 0x7FFF and 0x8000, which appear on `result` as 0x00007FFF and 0xFFFF8000.
- R3: A left shift by the word width or more clamps any nonzero operand as R2 describes. A zero operand gives zero with `overflow` low for any left count.
- R4: Without rounding, a right shift is arithmetic. A count magnitude of at least the word width minus one gives all ones for a negative operand and zero otherwise.
- R5: With `round_en` high, a right shift by m adds one to the arithmetic result when bit m-1 of the operand is set. A shift by 0 returns the operand unchanged.
- R6: With `round_en` high, a right shift by more than the word width minus one returns zero. This applies above 15 in 16-bit mode and above 31 in 32-bit mode.
- R7: When `wide_mode` is 0, only `operand[15:0]` is used, and `result` is the 16-bit answer sign-extended to 32 bits. When `wide_mode` is 1, the full 32 bits are used.
- R8: `overflow` is high for exactly the cycle whose `result` was clamped by a left shift. It is never high for a right shift.
- R9: `result`, `overflow` and `out_valid` update on the clock edge that samples `in_valid` high. `out_valid` is high for that one cycle only. `result` holds while `in_valid` is low.
- R10: A synchronous reset with `rst_n` low clears `result`, `overflow` and `out_valid`.
- R11: `round_en` has no effect on left shifts, which includes counts of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Qualifies the operand, count and mode inputs |
| operand | input | 32 | Signed operand; 16-bit mode uses bits 15:0 |
| shift_cnt | input | 8 | Signed count; negative means shift right |
| wide_mode | input | 1 | 1 selects a 32-bit word, 0 selects a 16-bit word |
| round_en | input | 1 | Enables round-half-up on right shifts |
| out_valid | output | 1 | One-cycle strobe marking a new result |
| result | output | 32 | Registered shifted value, sign-extended in 16-bit mode |
| overflow | output | 1 | The registered result was clamped |

## Verification
The assertions assume that `operand`, `shift_cnt`, `wide_mode` and `round_en` carry known values whenever `in_valid` is high. They also assume that a count's direction is read from its top bit in the cycle it is sampled. The checks tie the overflow flag to the clamp values and to left shifts only, and they check the sign extension in 16-bit mode. The bench drives every input on the falling edge, holds it through the sampling edge, and lowers `in_valid` afterwards. Every sampled cycle therefore carries fully defined stimulus.

// File: rtl/shf_pkg.sv
// Package: shared widths and the shift direction type for the shifter.
// Assumes: consumers take their default parameters from these constants.
package shf_pkg;
    localparam int SHF_WIDE_W   = 32;
    localparam int SHF_NARROW_W = 16;
    localparam int SHF_CNT_W    = 8;

    typedef enum logic {
        SHF_DIR_RIGHT = 1'b0,
        SHF_DIR_LEFT  = 1'b1
    } shf_dir_e;
endpackage

// File: rtl/shf_cnt_decode.sv
// Module: turns a signed count into a direction and an unsigned magnitude.
// Assumes: MAG_W is one bit wider than CNT_W so that the most negative
// count has a representable magnitude.
module shf_cnt_decode #(
    parameter int CNT_W = shf_pkg::SHF_CNT_W,
    parameter int MAG_W = CNT_W + 1
) (
    input  logic signed [CNT_W-1:0] cnt,
    output shf_pkg::shf_dir_e       dir,
    output logic [MAG_W-1:0]        mag
);
    logic [MAG_W-1:0] ext;

    // Split sign from size; a negative count reverses the direction.
    always_comb begin
        ext = MAG_W'(cnt);
        if (cnt[CNT_W-1]) begin
            dir = shf_pkg::SHF_DIR_RIGHT;
            mag = -ext;
        end else begin
            dir = shf_pkg::SHF_DIR_LEFT;
            mag = ext;
        end
    end
endmodule

// File: rtl/shf_left_sat.sv
// Module: left shift that clamps instead of wrapping.
// Assumes: x is two's complement. Any amount of W or more counts as
// an overflow for a nonzero operand.
module shf_left_sat #(
    parameter int W     = 32,
    parameter int MAG_W = 9
) (
    input  logic [W-1:0]     x,
    input  logic [MAG_W-1:0] mag,
    output logic [W-1:0]     y,
    output logic             clamp
);
    localparam int LW = $clog2(W);
    localparam logic [W-1:0] POS_MAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] NEG_MIN = {1'b1, {(W-1){1'b0}}};

    logic [2*W-1:0] spread;
    logic           too_far;
    logic           fits;
    logic           is_zero;

    // Shift into a double-width copy and test that the bits above the sign agree.
    always_comb begin
        too_far = (mag >= MAG_W'(W));
        spread  = {{W{x[W-1]}}, x} << mag[LW-1:0];
        fits    = (spread[2*W-1:W-1] == {(W+1){1'b0}}) ||
                  (spread[2*W-1:W-1] == {(W+1){1'b1}});
        is_zero = (x == '0);
        if (is_zero) begin
            y     = '0;
            clamp = 1'b0;
        end else if (too_far || !fits) begin
            y     = x[W-1] ? NEG_MIN : POS_MAX;
            clamp = 1'b1;
        end else begin
            y     = spread[W-1:0];
            clamp = 1'b0;
        end
    end
endmodule

// File: rtl/shf_right_rnd.sv
// Module: arithmetic right shift with optional round-half-up.
// Assumes: amounts at or above W-1 fill with the sign. With rounding on,
// amounts above W-1 give zero.
module shf_right_rnd #(
    parameter int W     = 32,
    parameter int MAG_W = 9
) (
    input  logic [W-1:0]     x,
    input  logic [MAG_W-1:0] mag,
    input  logic             rnd,
    output logic [W-1:0]     y
);
    localparam int LW = $clog2(W);
    localparam logic [MAG_W-1:0] TOP = MAG_W'(W - 1);

    logic [LW-1:0]        amt;
    logic [LW-1:0]        rbit_idx;
    logic                 rbit;
    logic signed [W-1:0]  base;

    // Limit the amount, shift, then add back the last bit dropped when rounding.
    always_comb begin
        amt      = (mag >= TOP) ? TOP[LW-1:0] : mag[LW-1:0];
        base     = $signed(x) >>> amt;
        rbit_idx = mag[LW-1:0] - LW'(1);
        rbit     = (mag != '0) && (mag <= TOP) && x[rbit_idx];
        if (!rnd) begin
            y = base;
        end else if (mag > TOP) begin
            y = '0;
        end else begin
            y = base + W'(rbit);
        end
    end
endmodule

// File: rtl/shf_lane.sv
// Module: one word width of the shifter, picking the left or right unit.
// Assumes: dir and mag come from shf_cnt_decode. A clamp is reported
// only for the left direction.
module shf_lane #(
    parameter int W     = 32,
    parameter int MAG_W = 9
) (
    input  logic [W-1:0]      x,
    input  shf_pkg::shf_dir_e dir,
    input  logic [MAG_W-1:0]  mag,
    input  logic              rnd,
    output logic [W-1:0]      y,
    output logic              clamp
);
    logic [W-1:0] left_y;
    logic [W-1:0] right_y;
    logic         left_clamp;

    shf_left_sat #(.W(W), .MAG_W(MAG_W)) u_left (
        .x(x), .mag(mag), .y(left_y), .clamp(left_clamp)
    );

    shf_right_rnd #(.W(W), .MAG_W(MAG_W)) u_right (
        .x(x), .mag(mag), .rnd(rnd), .y(right_y)
    );

    // Select the direction; rounding only exists on the right path.
    always_comb begin
        if (dir == shf_pkg::SHF_DIR_LEFT) begin
            y     = left_y;
            clamp = left_clamp;
        end else begin
            y     = right_y;
            clamp = 1'b0;
        end
    end
endmodule

// File: rtl/sat_shifter.sv
// Module: top level of the saturating bidirectional shifter. It has two
// lanes (narrow and wide), a mode select, and a registered result with
// a valid strobe.
// Assumes: inputs are known when in_valid is high. The reset is
// synchronous and active low.
module sat_shifter #(
    parameter int WIDE_W   = shf_pkg::SHF_WIDE_W,
    parameter int NARROW_W = shf_pkg::SHF_NARROW_W,
    parameter int CNT_W    = shf_pkg::SHF_CNT_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [WIDE_W-1:0]       operand,
    input  logic signed [CNT_W-1:0] shift_cnt,
    input  logic                    wide_mode,
    input  logic                    round_en,
    output logic                    out_valid,
    output logic [WIDE_W-1:0]       result,
    output logic                    overflow
);
    localparam int MAG_W  = CNT_W + 1;
    localparam int NLANES = 2;
    localparam logic [WIDE_W-1:0] W_MAX = {1'b0, {(WIDE_W-1){1'b1}}};
    localparam logic [WIDE_W-1:0] W_MIN = {1'b1, {(WIDE_W-1){1'b0}}};
    localparam logic [WIDE_W-1:0] N_MAX = WIDE_W'({1'b0, {(NARROW_W-1){1'b1}}});
    localparam logic [WIDE_W-1:0] N_MIN = {{(WIDE_W-NARROW_W+1){1'b1}}, {(NARROW_W-1){1'b0}}};

    shf_pkg::shf_dir_e  dir;
    logic [MAG_W-1:0]   mag;
    logic [WIDE_W-1:0]  lane_y     [NLANES];
    logic               lane_clamp [NLANES];
    logic [WIDE_W-1:0]  sel_y;
    logic               sel_clamp;

    shf_cnt_decode #(.CNT_W(CNT_W), .MAG_W(MAG_W)) u_dec (
        .cnt(shift_cnt), .dir(dir), .mag(mag)
    );

    // Lane 0 handles the narrow word, lane 1 the wide word.
    for (genvar g = 0; g < NLANES; g++) begin : g_lane
        localparam int LANE_W = (g == 0) ? NARROW_W : WIDE_W;
        logic [LANE_W-1:0] y;
        shf_lane #(.W(LANE_W), .MAG_W(MAG_W)) u_lane (
            .x(operand[LANE_W-1:0]), .dir(dir), .mag(mag), .rnd(round_en),
            .y(y), .clamp(lane_clamp[g])
        );
        assign lane_y[g] = WIDE_W'($signed(y));
    end

    // Choose the lane that matches the word mode.
    always_comb begin
        sel_y     = wide_mode ? lane_y[1]     : lane_y[0];
        sel_clamp = wide_mode ? lane_clamp[1] : lane_clamp[0];
    end

    // Capture the result on each accepted input; strobe valid and overflow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            overflow  <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            overflow  <= in_valid & sel_clamp;
            if (in_valid) begin
                result <= sel_y;
            end
        end
    end

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R9
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R9
    AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result)); // R9
    AST_OVF_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> out_valid); // R8
    AST_RIGHT_NO_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && shift_cnt[CNT_W-1]) |=> !overflow); // R8
    AST_CLAMP_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> (result == W_MAX || result == W_MIN ||
                      result == N_MAX || result == N_MIN)); // R2
    AST_ZERO_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && wide_mode && operand == '0 && !shift_cnt[CNT_W-1])
        |=> (result == '0 && !overflow)); // R3
    AST_NARROW_SEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !wide_mode) |=>
        (result[WIDE_W-1:NARROW_W-1] == '0 || result[WIDE_W-1:NARROW_W-1] == '1)); // R7
endmodule

// File: tb/sim_sat_shifter.sv
module sim_sat_shifter;
    localparam int NV = 30;
    // Row: {req[7:0], wide, rnd, cnt[7:0], operand[31:0], expect[31:0], ovf}
    localparam logic [82:0] VEC [NV] = '{
        {8'd1,  1'b1, 1'b0, 8'h04, 32'h00001234, 32'h00012340, 1'b0}, // R1 left
        {8'd1,  1'b1, 1'b0, 8'hFC, 32'h00012345, 32'h00001234, 1'b0}, // R1 negative count goes right
        {8'd2,  1'b0, 1'b0, 8'h01, 32'h00004000, 32'h00007FFF, 1'b1}, // R2 narrow positive clamp
        {8'd2,  1'b0, 1'b0, 8'h02, 32'h0000C000, 32'hFFFF8000, 1'b1}, // R2 narrow negative clamp
        {8'd2,  1'b0, 1'b0, 8'h01, 32'h0000C000, 32'hFFFF8000, 1'b0}, // R2 exact fit
        {8'd2,  1'b1, 1'b0, 8'h01, 32'h40000000, 32'h7FFFFFFF, 1'b1}, // R2 wide positive clamp
        {8'd2,  1'b1, 1'b0, 8'h03, 32'hF0000000, 32'h80000000, 1'b0}, // R2 wide exact fit
        {8'd2,  1'b1, 1'b0, 8'h04, 32'hF0000000, 32'h80000000, 1'b1}, // R2 wide negative clamp
        {8'd3,  1'b0, 1'b0, 8'h10, 32'h00000001, 32'h00007FFF, 1'b1}, // R3 narrow count 16
        {8'd3,  1'b1, 1'b0, 8'h28, 32'hFFFFFFFF, 32'h80000000, 1'b1}, // R3 wide count 40
        {8'd3,  1'b1, 1'b0, 8'h7F, 32'h00000000, 32'h00000000, 1'b0}, // R3 zero operand
        {8'd3,  1'b0, 1'b0, 8'h0F, 32'h0000FFFF, 32'hFFFF8000, 1'b0}, // R3 count 15 of -1
        {8'd4,  1'b1, 1'b0, 8'hF8, 32'h80000000, 32'hFF800000, 1'b0}, // R4 arithmetic
        {8'd4,  1'b0, 1'b0, 8'hEC, 32'h00008001, 32'hFFFFFFFF, 1'b0}, // R4 narrow sign fill
        {8'd4,  1'b0, 1'b0, 8'hF1, 32'h00007FFF, 32'h00000000, 1'b0}, // R4 narrow by 15
        {8'd1,  1'b1, 1'b0, 8'h80, 32'h80000000, 32'hFFFFFFFF, 1'b0}, // R1 count -128
        {8'd4,  1'b1, 1'b0, 8'hE1, 32'h7FFFFFFF, 32'h00000000, 1'b0}, // R4 wide by 31
        {8'd5,  1'b1, 1'b1, 8'hFC, 32'h00000018, 32'h00000002, 1'b0}, // R5 round up
        {8'd5,  1'b1, 1'b1, 8'hFC, 32'h00000017, 32'h00000001, 1'b0}, // R5 no round
        {8'd5,  1'b0, 1'b1, 8'hFF, 32'h0000FFFF, 32'h00000000, 1'b0}, // R5 -1 rounds to 0
        {8'd5,  1'b0, 1'b1, 8'hFE, 32'h0000FFFA, 32'hFFFFFFFF, 1'b0}, // R5 negative half
        {8'd5,  1'b1, 1'b1, 8'h00, 32'h12345678, 32'h12345678, 1'b0}, // R5 count 0
        {8'd6,  1'b0, 1'b1, 8'hF0, 32'h0000FFFF, 32'h00000000, 1'b0}, // R6 narrow by 16
        {8'd6,  1'b1, 1'b1, 8'hE0, 32'h80000000, 32'h00000000, 1'b0}, // R6 wide by 32
        {8'd6,  1'b1, 1'b1, 8'hE1, 32'h80000000, 32'hFFFFFFFF, 1'b0}, // R6 wide by 31
        {8'd6,  1'b0, 1'b1, 8'hF1, 32'h0000C000, 32'h00000000, 1'b0}, // R6 narrow by 15
        {8'd7,  1'b0, 1'b0, 8'h04, 32'hABCD0012, 32'h00000120, 1'b0}, // R7 upper bits ignored
        {8'd7,  1'b0, 1'b0, 8'hFC, 32'h1234F000, 32'hFFFFFF00, 1'b0}, // R7 sign extension
        {8'd11, 1'b1, 1'b1, 8'h01, 32'h40000000, 32'h7FFFFFFF, 1'b1}, // R11 clamp with round on
        {8'd11, 1'b0, 1'b1, 8'h03, 32'h00000005, 32'h00000028, 1'b0}  // R11 left with round on
    };

    logic              clk;
    logic              rst_n;
    logic              in_valid;
    logic [31:0]       operand;
    logic signed [7:0] shift_cnt;
    logic              wide_mode;
    logic              round_en;
    logic              out_valid;
    logic [31:0]       result;
    logic              overflow;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    sat_shifter u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .operand(operand),
        .shift_cnt(shift_cnt), .wide_mode(wide_mode), .round_en(round_en),
        .out_valid(out_valid), .result(result), .overflow(overflow)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic drive(input logic w, input logic r, input logic [7:0] c, input logic [31:0] op);
        @(negedge clk);
        wide_mode = w;
        round_en  = r;
        shift_cnt = c;
        operand   = op;
        in_valid  = 1'b1;
        @(negedge clk);
        in_valid  = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; operand = '0; shift_cnt = '0;
        wide_mode = 1'b1; round_en = 1'b0;
        repeat (3) @(negedge clk);
        check("R10 reset result", result, 32'h0);
        check("R10 reset out_valid", {31'd0, out_valid}, 32'h0);
        check("R10 reset overflow", {31'd0, overflow}, 32'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [82:0] v;
            string tag;
            v = VEC[i];
            tag = $sformatf("R%0d vec %0d", v[82:75], i);
            drive(v[74], v[73], v[72:65], v[64:33]);
            check({tag, " result"}, result, v[32:1]);
            check({tag, " overflow"}, {31'd0, overflow}, {31'd0, v[0]});
            check({tag, " out_valid"}, {31'd0, out_valid}, 32'h1);
        end

        // R9 and R8: the strobe and the flag drop and the result holds.
        drive(1'b1, 1'b0, 8'h01, 32'h40000000);
        check("R8 clamp flagged", {31'd0, overflow}, 32'h1);
        operand = 32'h00000001; shift_cnt = 8'sd2;
        @(negedge clk);
        check("R9 out_valid one cycle", {31'd0, out_valid}, 32'h0);
        check("R8 overflow one cycle", {31'd0, overflow}, 32'h0);
        check("R9 result holds", result, 32'h7FFFFFFF);

        // R10: reset clears the state even while in_valid is high.
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b1;
        @(negedge clk);
        check("R10 reset clears result", result, 32'h0);
        check("R10 reset clears valid", {31'd0, out_valid}, 32'h0);
        check("R10 reset clears overflow", {31'd0, overflow}, 32'h0);
        in_valid = 1'b0; rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule